// File: doc/BRIEF.md
# USB Packet Receive Checker

This block watches the receive side of an 8-bit parallel USB transceiver interface and handles one packet at a time. A packet is the whole stretch during which the line-active input is high. Bytes are taken only on cycles where the byte-valid strobe and line-active are both high. The first byte taken is the packet identifier. Every byte between the identifier and the final two is payload. For data packets the final two bytes are the check trailer.

Payload bytes leave on a valid/ready stream. The block holds back the two most recent bytes so the trailer never appears on the stream. The receive interface cannot be stalled, so the stream has one output register and no queue. A byte on the stream stays stable until it is accepted. If the next payload byte is ready to leave while the previous one has not been taken, the new byte is dropped and an overrun flag is raised. The sink must therefore accept each byte before the next payload byte arrives. When line-active falls, the block emits a one-cycle done pulse together with the identifier, the payload length and four error flags. These values are held until the next done.

Top module: `usbrx_checker`

## Requirements
- R1: A byte is captured only in a cycle where `rx_active` and `rx_valid` are both high; `rx_data` in any other cycle has no effect on the count, the identifier or the payload.
- R2: `pkt_done` is high for exactly one cycle, the cycle after the first cycle in which `rx_active` is sampled low following a high period. `pkt_pid`, `pkt_len` and `pkt_err` change only together with `pkt_done` and otherwise hold.
- R3: `pkt_pid` reports bits [3:0] of the first captured byte. `pkt_err[0]` (identifier error) is set when bits [7:4] differ from the bitwise complement of bits [3:0], or when no byte was captured; in that case `pkt_pid` is 0.
- R4: Packets whose identifier has bits [1:0] equal to 2'b11 are data packets. For these, a CRC16 is computed with polynomial x^16+x^15+x^2+1, seeded with 16'hFFFF, least significant bit of each byte first, over every byte after the identifier except the final two.
- R5: For a data packet, the final two bytes must equal the bitwise complement of the CRC16 remainder, low byte first. `pkt_err[1]` (check error) is set on a mismatch, or when a data packet has fewer than three bytes.
- R6: `pkt_len` equals the captured byte count minus three, or 0 when fewer than three bytes were captured.
- R7: A one-byte packet (handshake) is reported with `pkt_len` 0, no forwarded bytes and `pkt_err[1]` clear.
- R8: A packet whose identifier is not a data identifier never sets `pkt_err[1]`.
- R9: `pkt_err[2]` (line error) is set when `rx_error` is high in any cycle where `rx_active` is high during the packet.
- R10: Payload bytes are forwarded on `pay_data`/`pay_valid` in arrival order, excluding the identifier and the final two bytes. While `pay_valid` is high and `pay_ready` is low, `pay_valid` and `pay_data` hold.
- R11: If a payload byte is ready to leave while `pay_valid` is high and `pay_ready` is low, that new byte is discarded, the held byte is kept, and `pkt_err[3]` (overrun) is set for the packet.
- R12: After reset, `pkt_done`, `pay_valid`, `pkt_pid`, `pkt_len` and `pkt_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | High for the duration of one received packet |
| rx_valid | input | 1 | Strobe marking a valid byte on `rx_data` |
| rx_error | input | 1 | Receive error reported by the transceiver |
| rx_data | input | 8 | Received byte |
| pay_valid | output | 1 | Payload byte available |
| pay_ready | input | 1 | Sink accepts the payload byte |
| pay_data | output | 8 | Payload byte |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| pkt_pid | output | 4 | Identifier of the last packet |
| pkt_len | output | $clog2(MAX_BYTES+1) | Payload length of the last packet |
| pkt_err | output | 4 | {overrun, line error, check error, identifier error} |

## Verification
The assertions check on every cycle the timing of the done pulse relative to the fall of `rx_active`, and that the report holds between pulses. They also check that a stalled payload byte stays put, that the stream only starts on a captured byte, and that non-data identifiers never produce a check error. Only the bench scenarios can show that the checksum arithmetic, the trailer byte order, the length trimming and the exact forwarded byte sequence are right. The same goes for dropping bytes that arrive outside a valid strobe or during an overrun, because those depend on whole packets built from an independent checksum model.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int CRC_W  = 16;
  localparam int ERR_W  = 4;

  // flag positions inside the error vector
  localparam int ERR_PID  = 0;
  localparam int ERR_CRC  = 1;
  localparam int ERR_LINE = 2;
  localparam int ERR_OVR  = 3;

  localparam logic [CRC_W-1:0] CRC_SEED     = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'hA001; // reflected x^16+x^15+x^2+1

  // one byte, least significant bit first, reflected register
  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c_in,
                                                  input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REV;
    end
    return c;
  endfunction

  function automatic logic pid_is_data(input logic [NIB_W-1:0] pid);
    return pid[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/usbrx_pid_check.sv
module usbrx_pid_check
  import usbrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic [NIB_W-1:0]  pid,
  output logic              pid_ok
);
  logic [NIB_W-1:0] hi_nib;
  logic [NIB_W-1:0] lo_nib;

  assign hi_nib = din[BYTE_W-1:NIB_W];
  assign lo_nib = din[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid    <= '0;
      pid_ok <= 1'b0;
    end else if (take) begin
      pid    <= lo_nib;
      pid_ok <= (hi_nib == ~lo_nib);
    end
  end
endmodule

// File: rtl/usbrx_delay_line.sv
module usbrx_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     din,
  output logic             pop,
  output logic [W-1:0]     dout,
  output logic [DEPTH*W-1:0] contents
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [W-1:0]      slot [DEPTH];
  logic [FILL_W-1:0] fill_q;
  logic              full;

  assign full = (fill_q == FILL_W'(DEPTH));
  assign pop  = push && full;
  assign dout = slot[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) fill_q <= '0;
    else if (push && !full) fill_q <= fill_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot[0] <= '0;
    else if (push) slot[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rst_n) slot[g] <= '0;
      else if (push) slot[g] <= slot[g-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign contents[g*W +: W] = slot[g];
  end
endmodule

// File: rtl/usbrx_crc16.sv
module usbrx_crc16
  import usbrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc <= CRC_SEED;
    else if (en) crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/usbrx_out_stage.sv
module usbrx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         o_valid,
  input  logic         o_ready,
  output logic [W-1:0] o_data,
  output logic         overrun
);
  logic slot_free;

  assign slot_free = !o_valid || o_ready;
  assign overrun   = load && !slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (load && slot_free) begin
      o_valid <= 1'b1;
      o_data  <= din;
    end else if (o_valid && o_ready) begin
      o_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usbrx_checker.sv
module usbrx_checker
  import usbrx_pkg::*;
#(
  parameter int MAX_BYTES = 1027
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rx_active,
  input  logic                             rx_valid,
  input  logic                             rx_error,
  input  logic [7:0]                       rx_data,
  output logic                             pay_valid,
  input  logic                             pay_ready,
  output logic [7:0]                       pay_data,
  output logic                             pkt_done,
  output logic [3:0]                       pkt_pid,
  output logic [$clog2(MAX_BYTES+1)-1:0]   pkt_len,
  output logic [3:0]                       pkt_err
);
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int CRC_BYTES = CRC_W / BYTE_W;
  localparam int OVERHEAD  = 1 + CRC_BYTES;

  logic              active_q;
  logic [LEN_W-1:0]  count_q;
  logic              line_err_q;
  logic              ovr_q;
  logic              take, first_take, body_take, pkt_end;

  logic [NIB_W-1:0]  pid;
  logic              pid_ok;
  logic              pop;
  logic [BYTE_W-1:0] pop_byte;
  logic [CRC_BYTES*BYTE_W-1:0] held;
  logic [CRC_W-1:0]  trail_word;
  logic [CRC_W-1:0]  crc_q;
  logic              overrun;

  logic [NIB_W-1:0]  nxt_pid;
  logic [LEN_W-1:0]  nxt_len;
  logic [ERR_W-1:0]  nxt_err;
  logic              none_seen, too_short, data_pkt, crc_bad;

  assign take       = rx_active && rx_valid;
  assign first_take = take && (count_q == '0);
  assign body_take  = take && (count_q != '0);
  assign pkt_end    = active_q && !rx_active;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= rx_active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pkt_end) count_q <= '0;
    else if (take && count_q != LEN_W'(MAX_BYTES)) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pkt_end) begin
      line_err_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (rx_active && rx_error) line_err_q <= 1'b1;
      if (overrun)               ovr_q      <= 1'b1;
    end
  end

  usbrx_pid_check u_pid (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (first_take),
    .din    (rx_data),
    .pid    (pid),
    .pid_ok (pid_ok)
  );

  usbrx_delay_line #(.W(BYTE_W), .DEPTH(CRC_BYTES)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pkt_end),
    .push     (body_take),
    .din      (rx_data),
    .pop      (pop),
    .dout     (pop_byte),
    .contents (held)
  );

  // held slot 0 is the newest byte; trailer low byte arrived first
  for (genvar k = 0; k < CRC_BYTES; k++) begin : g_trail
    assign trail_word[k*BYTE_W +: BYTE_W] = held[(CRC_BYTES-1-k)*BYTE_W +: BYTE_W];
  end

  usbrx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pkt_end),
    .en    (pop),
    .din   (pop_byte),
    .crc   (crc_q)
  );

  usbrx_out_stage #(.W(BYTE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pop),
    .din     (pop_byte),
    .o_valid (pay_valid),
    .o_ready (pay_ready),
    .o_data  (pay_data),
    .overrun (overrun)
  );

  always_comb begin
    none_seen = (count_q == '0);
    too_short = (count_q < LEN_W'(OVERHEAD));
    data_pkt  = !none_seen && pid_is_data(pid);
    crc_bad   = data_pkt && (too_short || (trail_word != ~crc_q));
    nxt_pid   = none_seen ? '0 : pid;
    nxt_len   = too_short ? '0 : count_q - LEN_W'(OVERHEAD);
    nxt_err           = '0;
    nxt_err[ERR_PID]  = none_seen || !pid_ok;
    nxt_err[ERR_CRC]  = crc_bad;
    nxt_err[ERR_LINE] = line_err_q;
    nxt_err[ERR_OVR]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_done <= 1'b0;
      pkt_pid  <= '0;
      pkt_len  <= '0;
      pkt_err  <= '0;
    end else begin
      pkt_done <= pkt_end;
      if (pkt_end) begin
        pkt_pid <= nxt_pid;
        pkt_len <= nxt_len;
        pkt_err <= nxt_err;
      end
    end
  end
endmodule

// File: rtl/usbrx_checker_sva.sv
module usbrx_checker_sva #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_active,
  input logic             rx_valid,
  input logic             pay_valid,
  input logic             pay_ready,
  input logic [7:0]       pay_data,
  input logic             pkt_done,
  input logic [3:0]       pkt_pid,
  input logic [LEN_W-1:0] pkt_len,
  input logic [3:0]       pkt_err
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  a_r2_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (!$past(rx_active) && $past(rx_active, 2)));

  a_r2_report_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |-> ($stable(pkt_pid) && $stable(pkt_len) && $stable(pkt_err)));

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |=> (pay_valid && $stable(pay_data)));

  a_r10_start_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pay_valid) |-> $past(rx_active && rx_valid));

  a_r8_no_crc_on_nondata: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_pid[1:0] != 2'b11) |-> !pkt_err[1]);
endmodule

bind usbrx_checker usbrx_checker_sva #(.LEN_W(LEN_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_active (rx_active),
  .rx_valid  (rx_valid),
  .pay_valid (pay_valid),
  .pay_ready (pay_ready),
  .pay_data  (pay_data),
  .pkt_done  (pkt_done),
  .pkt_pid   (pkt_pid),
  .pkt_len   (pkt_len),
  .pkt_err   (pkt_err)
);

// File: tb/usbrx_checker_bench.sv
module usbrx_checker_bench;
  localparam int MAXB  = 1027;
  localparam int LEN_W = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_active = 1'b0, rx_valid = 1'b0, rx_error = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic pay_valid, pay_ready = 1'b1;
  logic [7:0] pay_data;
  logic pkt_done;
  logic [3:0] pkt_pid;
  logic [LEN_W-1:0] pkt_len;
  logic [3:0] pkt_err;

  always #10 clk = ~clk;

  usbrx_checker #(.MAX_BYTES(MAXB)) u_usbrx_checker (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_error(rx_error), .rx_data(rx_data), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .pay_data(pay_data), .pkt_done(pkt_done),
    .pkt_pid(pkt_pid), .pkt_len(pkt_len), .pkt_err(pkt_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] pkt [80];
  int pkt_n;
  logic [7:0] rcv [80];
  int rcv_n = 0;
  logic got_done, got_after;
  logic [3:0] got_pid, got_err;
  int got_len;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // stream sink sampled away from both clock edges
  always begin
    @(negedge clk);
    #2;
    if (pay_valid && pay_ready && rcv_n < 80) begin
      rcv[rcv_n] = pay_data;
      rcv_n++;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // independent model: MSB-first register on mirrored bytes, mirrored back at the end
  task automatic mk_data(input logic [3:0] pid, input int npay, input logic [7:0] base);
    logic [15:0] c;
    logic [7:0] x;
    logic fb;
    pkt[0] = {~pid, pid};
    c = 16'hFFFF;
    for (int i = 0; i < npay; i++) begin
      pkt[i+1] = base + 8'(i * 37);
      x = rev8(pkt[i+1]);
      for (int j = 7; j >= 0; j--) begin
        fb = c[15] ^ x[j];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    end
    pkt[npay+1] = ~rev8(c[15:8]);
    pkt[npay+2] = ~rev8(c[7:0]);
    pkt_n = npay + 3;
  endtask

  task automatic drive(input int gap, input bit stall, input int err_at);
    rcv_n = 0;
    @(negedge clk);
    rx_active = 1'b1;
    @(negedge clk);
    for (int i = 0; i < pkt_n; i++) begin
      rx_valid = 1'b1;
      rx_data  = pkt[i];
      rx_error = (i == err_at);
      if (stall) pay_ready = 1'b0;
      @(negedge clk);
      rx_error = 1'b0;
      for (int g = 0; g < gap; g++) begin
        rx_valid = 1'b0;
        rx_data  = 8'hE0 ^ 8'(i);
        if (stall && g == gap - 1) pay_ready = 1'b1;
        @(negedge clk);
      end
    end
    rx_valid  = 1'b0;
    rx_active = 1'b0;
    @(negedge clk);
    got_done = pkt_done;
    got_pid  = pkt_pid;
    got_len  = int'(pkt_len);
    got_err  = pkt_err;
    @(negedge clk);
    got_after = pkt_done;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_report(input string tag, input logic [3:0] pid, input int len,
                              input logic [3:0] err);
    chk("R2", {tag, " done pulse"}, int'(got_done), 1);
    chk("R2", {tag, " done single"}, int'(got_after), 0);
    chk(tag, "pid", int'(got_pid), int'(pid));
    chk(tag, "len", got_len, len);
    chk(tag, "err", int'(got_err), int'(err));
  endtask

  task automatic check_payload(input string tag, input int npay);
    int bad;
    bad = 0;
    chk(tag, "payload count", rcv_n, npay);
    for (int i = 0; i < npay && i < rcv_n; i++)
      if (rcv[i] != pkt[i+1]) bad++;
    chk(tag, "payload bytes wrong", bad, 0);
  endtask

  task automatic t_reset();
    chk("R12", "done", int'(pkt_done), 0);
    chk("R12", "pay_valid", int'(pay_valid), 0);
    chk("R12", "pid", int'(pkt_pid), 0);
    chk("R12", "len", int'(pkt_len), 0);
    chk("R12", "err", int'(pkt_err), 0);
  endtask

  task automatic t_basic();   // R4 R5 R6 R10
    mk_data(4'h3, 5, 8'h10);
    drive(0, 1'b0, -1);
    check_report("R6", 4'h3, 5, 4'b0000);
    check_payload("R10", 5);
  endtask

  task automatic t_gapped();  // R1: garbage between strobes ignored
    mk_data(4'hB, 7, 8'h81);
    drive(2, 1'b0, -1);
    check_report("R1", 4'hB, 7, 4'b0000);
    check_payload("R1", 7);
  endtask

  task automatic t_stall();   // R10 back-pressure without loss
    mk_data(4'h3, 4, 8'h42);
    drive(3, 1'b1, -1);
    check_report("R10", 4'h3, 4, 4'b0000);
    check_payload("R10", 4);
  endtask

  task automatic t_bad_crc();
    mk_data(4'h3, 6, 8'h05);
    pkt[pkt_n-1] = pkt[pkt_n-1] ^ 8'h10;
    drive(0, 1'b0, -1);
    check_report("R5", 4'h3, 6, 4'b0010);
  endtask

  task automatic t_swapped_trailer(); // R5 byte order
    logic [7:0] t;
    mk_data(4'hB, 2, 8'h9C);
    t = pkt[3]; pkt[3] = pkt[4]; pkt[4] = t;
    drive(0, 1'b0, -1);
    chk("R5", "swapped trailer flagged", int'(got_err[1]), int'(pkt[3] != pkt[4]));
  endtask

  task automatic t_bad_pid();
    mk_data(4'h3, 3, 8'h20);
    pkt[0] = 8'h33;
    drive(0, 1'b0, -1);
    check_report("R3", 4'h3, 3, 4'b0001);
  endtask

  task automatic t_handshake();
    pkt[0] = 8'hD2;
    pkt_n = 1;
    drive(0, 1'b0, -1);
    check_report("R7", 4'h2, 0, 4'b0000);
    chk("R7", "nothing forwarded", rcv_n, 0);
  endtask

  task automatic t_zero_len();
    mk_data(4'h3, 0, 8'h00);
    drive(0, 1'b0, -1);
    check_report("R4", 4'h3, 0, 4'b0000);
  endtask

  task automatic t_short();
    pkt[0] = 8'hC3; pkt[1] = 8'h12;
    pkt_n = 2;
    drive(0, 1'b0, -1);
    check_report("R5", 4'h3, 0, 4'b0010);
  endtask

  task automatic t_token();
    pkt[0] = 8'h69; pkt[1] = 8'h12; pkt[2] = 8'h34;
    pkt_n = 3;
    drive(0, 1'b0, -1);
    check_report("R8", 4'h9, 0, 4'b0000);
  endtask

  task automatic t_line_err();
    mk_data(4'hB, 3, 8'h70);
    drive(1, 1'b0, 2);
    check_report("R9", 4'hB, 3, 4'b0100);
    check_payload("R9", 3);
  endtask

  task automatic t_overrun();
    mk_data(4'h3, 3, 8'hA0);
    pay_ready = 1'b0;
    drive(0, 1'b0, -1);
    check_report("R11", 4'h3, 3, 4'b1000);
    pay_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "bytes after release", rcv_n, 1);
    chk("R11", "kept byte", int'(rcv[0]), int'(pkt[1]));
  endtask

  task automatic t_idle_valid();
    int seen;
    seen = 0;
    rcv_n = 0;
    for (int i = 0; i < 4; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'hA5;
      @(negedge clk);
      if (pkt_done || pay_valid) seen++;
    end
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "activity while idle", seen + int'(pkt_done), 0);
    mk_data(4'hB, 2, 8'h31);
    drive(0, 1'b0, -1);
    check_report("R1", 4'hB, 2, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_gapped();
    t_stall();
    t_bad_crc();
    t_swapped_trailer();
    t_bad_pid();
    t_handshake();
    t_zero_len();
    t_short();
    t_token();
    t_line_err();
    t_overrun();
    t_idle_valid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule